// File: doc/BRIEF.md
# Port Status LED Driver

This block turns the status of the two ports of a copper-to-fiber converter into lamp drive signals. The copper port has link, speed and duplex indicators. The fiber port has link, duplex, signal-present and far-end-fault indicators. Every output is active low, so a 0 on a pin lights its lamp. All inputs are level or single-cycle signals from the same clock domain as the block. The default clock is 25 MHz.

A prescaler divides the clock into a millisecond tick, and every lamp duration is a whole number of ticks. Short activity and collision pulses are stretched into complete blink cycles: a short lit phase followed by a long dark phase. A pulse that arrives while a cycle is running is remembered, and it starts a second cycle as soon as the first one ends. The far-end-fault lamp uses the inverse pattern: a long lit phase and a short dark phase. Its pattern restarts from the lit phase each time a fault begins.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain control or status level. Inputs are sampled on every clock and nothing exerts back-pressure.

Top module: `port_led_driver`

## Requirements
- R1: Every output is active low (0 = lit). With all inputs low, after reset, all seven outputs are 1.
- R2: A link lamp is dark while its port's link input is low, whatever the activity input does. It is steadily lit while the link is up and no blink cycle is running.
- R3: An activity pulse on a port whose link is up starts a blink cycle. The lamp is lit for SHORT_MS ticks and dark for LONG_MS ticks, then it returns to steady lit. A tick is TICK_DIV clocks.
- R4: A pulse that arrives during a running cycle is latched. When the current cycle ends, a second full cycle starts immediately.
- R5: The copper speed lamp is lit when the speed input is 1 (100M) and dark when it is 0 (10M).
- R6: A duplex lamp is steadily lit in full duplex (full input = 1), and collisions have no effect. In half duplex it is dark, and a collision pulse produces one blink cycle with the timing of R3.
- R7: The signal-detect lamp is lit while the fiber signal input is 1 and dark while it is 0.
- R8: While the fault input is 1, the far-end-fault lamp repeats LONG_MS ticks lit then SHORT_MS ticks dark. The pattern starts lit on the cycle the fault input rises. The lamp is dark while the fault input is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, 25 MHz by default |
| rst_n | input | 1 | Asynchronous active-low reset |
| cu_link | input | 1 | Copper port link up |
| cu_speed100 | input | 1 | Copper port speed, 1 = 100M |
| cu_full | input | 1 | Copper port full duplex |
| cu_act | input | 1 | Copper port activity pulse |
| cu_col | input | 1 | Copper port collision pulse |
| fb_link | input | 1 | Fiber port link up |
| fb_full | input | 1 | Fiber port full duplex |
| fb_act | input | 1 | Fiber port activity pulse |
| fb_col | input | 1 | Fiber port collision pulse |
| fb_sig | input | 1 | Fiber signal present |
| fb_fault | input | 1 | Far-end-fault pattern being received |
| lamp_cu_link_n | output | 1 | Copper link lamp, active low |
| lamp_cu_spd_n | output | 1 | Copper speed lamp, active low |
| lamp_cu_dpx_n | output | 1 | Copper duplex lamp, active low |
| lamp_fb_link_n | output | 1 | Fiber link lamp, active low |
| lamp_fb_dpx_n | output | 1 | Fiber duplex lamp, active low |
| lamp_fb_sig_n | output | 1 | Fiber signal lamp, active low |
| lamp_fb_flt_n | output | 1 | Far-end-fault lamp, active low |

## Verification
The bench sends a second activity pulse in the middle of a running cycle, then samples the lamp during the dark phase of the follow-on cycle. A design that dropped the pulse would show a steady lit lamp there instead. It raises collisions in full duplex and samples inside what would be the dark phase; a design that blinked there would wrongly darken a steady duplex lamp. It pulses activity with the link down, where a design that let the stretcher override the link would light the lamp. The far-end-fault lamp is sampled in its long lit phase, its short dark phase and the next lit phase. This catches a swapped or uninverted pattern and a counter that fails to restart on the fault's rising edge.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;
  localparam int NPORT = 2;

  typedef enum int {
    PORT_CU = 0,
    PORT_FB = 1
  } port_e;

  typedef struct packed {
    logic link;
    logic full;
    logic act;
    logic col;
  } port_stat_t;
endpackage

// File: rtl/ms_tick.sv
module ms_tick #(
  parameter int DIV = 25000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      // R3
      tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/blink_stretch.sv
module blink_stretch #(
  parameter int ON_T  = 20,
  parameter int OFF_T = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic pulse_i,
  output logic busy_o,
  output logic on_o
);
  localparam int PER = ON_T + OFF_T;
  localparam int CW  = $clog2(PER + 1);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);

  logic          busy_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = busy_q && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      pend_q <= 1'b0;
      if (pulse_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else begin
      if (tick_i) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap) begin
        busy_q <= pend_q || pulse_i;
        pend_q <= 1'b0;
      end else if (pulse_i) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign on_o   = busy_q && (cnt_q < CW'(ON_T));

  // R3
  start_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && pulse_i) |=> (busy_o && on_o));
  // R4
  pend_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wrap) |=> (busy_o && on_o));
endmodule

// File: rtl/fault_blink.sv
module fault_blink #(
  parameter int LIT_T  = 80,
  parameter int DARK_T = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic fault_i,
  output logic lit_o
);
  localparam int PER = LIT_T + DARK_T;
  localparam int CW  = $clog2(PER + 1);
  localparam logic [CW-1:0] LAST = CW'(PER - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!fault_i) cnt_q <= '0;
    else if (tick_i)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign lit_o = fault_i && (cnt_q < CW'(LIT_T));

  // R8
  fault_start_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_i) |-> lit_o);
endmodule

// File: rtl/port_led_driver.sv
module port_led_driver
  import led_drv_pkg::*;
#(
  parameter int TICK_DIV = 25000,
  parameter int SHORT_MS = 20,
  parameter int LONG_MS  = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cu_link,
  input  logic cu_speed100,
  input  logic cu_full,
  input  logic cu_act,
  input  logic cu_col,
  input  logic fb_link,
  input  logic fb_full,
  input  logic fb_act,
  input  logic fb_col,
  input  logic fb_sig,
  input  logic fb_fault,
  output logic lamp_cu_link_n,
  output logic lamp_cu_spd_n,
  output logic lamp_cu_dpx_n,
  output logic lamp_fb_link_n,
  output logic lamp_fb_dpx_n,
  output logic lamp_fb_sig_n,
  output logic lamp_fb_flt_n
);
  logic             tick;
  port_stat_t       stat [NPORT];
  logic [NPORT-1:0] link_lit, dpx_lit;
  logic             flt_lit;

  assign stat[PORT_CU] = '{link: cu_link, full: cu_full, act: cu_act, col: cu_col};
  assign stat[PORT_FB] = '{link: fb_link, full: fb_full, act: fb_act, col: fb_col};

  ms_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic act_busy, act_on, col_busy, col_on;

      blink_stretch #(.ON_T(SHORT_MS), .OFF_T(LONG_MS)) u_act (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .pulse_i(stat[p].act), .busy_o(act_busy), .on_o(act_on)
      );

      blink_stretch #(.ON_T(SHORT_MS), .OFF_T(LONG_MS)) u_col (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .pulse_i(stat[p].col), .busy_o(col_busy), .on_o(col_on)
      );

      assign link_lit[p] = stat[p].link && (!act_busy || act_on);
      assign dpx_lit[p]  = stat[p].full || (col_busy && col_on);
    end
  endgenerate

  fault_blink #(.LIT_T(LONG_MS), .DARK_T(SHORT_MS)) u_flt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .fault_i(fb_fault), .lit_o(flt_lit)
  );

  assign lamp_cu_link_n = ~link_lit[PORT_CU];
  assign lamp_fb_link_n = ~link_lit[PORT_FB];
  assign lamp_cu_dpx_n  = ~dpx_lit[PORT_CU];
  assign lamp_fb_dpx_n  = ~dpx_lit[PORT_FB];
  assign lamp_cu_spd_n  = ~cu_speed100;
  assign lamp_fb_sig_n  = ~fb_sig;
  assign lamp_fb_flt_n  = ~flt_lit;

  // R2
  cu_link_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cu_link |-> lamp_cu_link_n);
  // R2
  fb_link_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_link |-> lamp_fb_link_n);
  // R6
  full_dpx_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_full && $past(cu_full)) |-> (!lamp_cu_dpx_n && $stable(lamp_cu_dpx_n)));
  // R8
  no_fault_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fb_fault |-> lamp_fb_flt_n);
endmodule

// File: tb/sim_port_led_driver.sv
module sim_port_led_driver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cu_link = 0, cu_speed100 = 0, cu_full = 0, cu_act = 0, cu_col = 0;
  logic fb_link = 0, fb_full = 0, fb_act = 0, fb_col = 0, fb_sig = 0, fb_fault = 0;
  logic lamp_cu_link_n, lamp_cu_spd_n, lamp_cu_dpx_n;
  logic lamp_fb_link_n, lamp_fb_dpx_n, lamp_fb_sig_n, lamp_fb_flt_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_led_driver #(.TICK_DIV(10), .SHORT_MS(4), .LONG_MS(16)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cu_link(cu_link), .cu_speed100(cu_speed100), .cu_full(cu_full),
    .cu_act(cu_act), .cu_col(cu_col),
    .fb_link(fb_link), .fb_full(fb_full), .fb_act(fb_act), .fb_col(fb_col),
    .fb_sig(fb_sig), .fb_fault(fb_fault),
    .lamp_cu_link_n(lamp_cu_link_n), .lamp_cu_spd_n(lamp_cu_spd_n),
    .lamp_cu_dpx_n(lamp_cu_dpx_n), .lamp_fb_link_n(lamp_fb_link_n),
    .lamp_fb_dpx_n(lamp_fb_dpx_n), .lamp_fb_sig_n(lamp_fb_sig_n),
    .lamp_fb_flt_n(lamp_fb_flt_n)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_cu_act();
    cu_act = 1; @(posedge clk); @(negedge clk); cu_act = 0;
  endtask

  task automatic test_reset();
    chk(lamp_cu_link_n, 1, "R1 reset cu link");
    chk(lamp_cu_spd_n,  1, "R1 reset cu speed");
    chk(lamp_cu_dpx_n,  1, "R1 reset cu duplex");
    chk(lamp_fb_link_n, 1, "R1 reset fb link");
    chk(lamp_fb_dpx_n,  1, "R1 reset fb duplex");
    chk(lamp_fb_sig_n,  1, "R1 reset fb signal");
    chk(lamp_fb_flt_n,  1, "R1 reset fb fault");
  endtask

  task automatic test_static();
    cu_speed100 = 1; fb_sig = 1; wait_neg(2);
    chk(lamp_cu_spd_n, 0, "R5 speed 100M lit");
    chk(lamp_fb_sig_n, 0, "R7 signal present lit");
    cu_speed100 = 0; fb_sig = 0; wait_neg(2);
    chk(lamp_cu_spd_n, 1, "R5 speed 10M dark");
    chk(lamp_fb_sig_n, 1, "R7 fiber unplugged dark");
    // R2: activity with link down leaves lamp dark
    pulse_cu_act(); wait_neg(4);
    chk(lamp_cu_link_n, 1, "R2 link down activity ignored");
    wait_neg(220);
    cu_link = 1; wait_neg(2);
    chk(lamp_cu_link_n, 0, "R2 link up steady lit");
  endtask

  task automatic test_blink();
    pulse_cu_act(); wait_neg(4);
    chk(lamp_cu_link_n, 0, "R3 cu lit phase");
    wait_neg(55);
    chk(lamp_cu_link_n, 1, "R3 cu dark phase early");
    wait_neg(90);
    chk(lamp_cu_link_n, 1, "R3 cu dark phase late");
    wait_neg(80);
    chk(lamp_cu_link_n, 0, "R3 cu back to steady");
    fb_link = 1; wait_neg(2);
    fb_act = 1; @(posedge clk); @(negedge clk); fb_act = 0;
    wait_neg(4);
    chk(lamp_fb_link_n, 0, "R3 fb lit phase");
    wait_neg(55);
    chk(lamp_fb_link_n, 1, "R3 fb dark phase");
    wait_neg(170);
    chk(lamp_fb_link_n, 0, "R3 fb back to steady");
  endtask

  task automatic test_pending();
    pulse_cu_act(); wait_neg(40);
    pulse_cu_act();
    wait_neg(164);
    chk(lamp_cu_link_n, 0, "R4 second cycle lit");
    wait_neg(45);
    chk(lamp_cu_link_n, 1, "R4 second cycle dark");
    wait_neg(170);
    chk(lamp_cu_link_n, 0, "R4 steady after second cycle");
  endtask

  task automatic test_duplex();
    cu_full = 1; wait_neg(2);
    chk(lamp_cu_dpx_n, 0, "R6 full steady lit");
    cu_col = 1; @(posedge clk); @(negedge clk); cu_col = 0;
    wait_neg(60);
    chk(lamp_cu_dpx_n, 0, "R6 full collision ignored");
    wait_neg(180);
    cu_full = 0; wait_neg(2);
    chk(lamp_cu_dpx_n, 1, "R6 half idle dark");
    fb_col = 1; @(posedge clk); @(negedge clk); fb_col = 0;
    wait_neg(4);
    chk(lamp_fb_dpx_n, 0, "R6 half collision lit");
    wait_neg(55);
    chk(lamp_fb_dpx_n, 1, "R6 half collision dark phase");
    wait_neg(170);
    chk(lamp_fb_dpx_n, 1, "R6 half after cycle dark");
  endtask

  task automatic test_fault();
    fb_fault = 1; wait_neg(100);
    chk(lamp_fb_flt_n, 0, "R8 long lit phase");
    wait_neg(75);
    chk(lamp_fb_flt_n, 1, "R8 short dark phase");
    wait_neg(40);
    chk(lamp_fb_flt_n, 0, "R8 next lit phase");
    fb_fault = 0; wait_neg(2);
    chk(lamp_fb_flt_n, 1, "R8 no fault dark");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  initial begin
    wait_neg(3);
    test_reset();
    rst_n = 1;
    wait_neg(2);
    test_reset();
    test_static();
    test_blink();
    test_pending();
    test_duplex();
    test_fault();
    done = 1;
    summary();
    $finish;
  end
endmodule